// File: doc/BRIEF.md
# Two-Port Banked Load Arbiter

This block sits ahead of a data array that is split into narrow, independently addressed banks. Each cycle it accepts up to two load requests, one per port. From each address it derives the bank the load targets and decides which loads may proceed in that cycle. Loads to different banks proceed together. A bank serves only one load per cycle, so two loads aimed at the same bank are serialised. The losing load is kept inside the block and is issued again in a following cycle.

Each port has a valid and address input and a ready output. The block drives a grant, a stall, a bank number and an error flag for each port. Ready drops while a port has a request held, and the caller keeps its next request until ready returns. A stride that is a whole multiple of the 256-byte bank span always lands both loads in the same bank. Such strides serialise, and priority alternates between the ports so that neither port is starved. Two loads to the same 16-byte word may share a single bank access.

Top module: `lbk_arbiter`

## Requirements
- R1: The bank output of a port that is granted or stalled equals bits 7 down to 4 of the address being served; 16 banks of 16 bytes each.
- R2: When both ports carry valid aligned loads to different banks, both are granted in the same cycle and neither stalls.
- R3: When both ports target the same bank at different 16-byte addresses, exactly one is granted and the other asserts stall in that cycle; address strides that are multiples of 256 bytes always conflict.
- R4: The port that lost a bank conflict wins the next conflict; the first conflict after reset goes to port 0.
- R5: A stalled load is held and presented again in the next cycle ahead of anything on its port's inputs, and ready of that port is low while the load is held.
- R6: A request offered on a port whose ready is low is ignored: it is neither granted, stalled nor remembered.
- R7: An accepted request whose address bits 3 down to 0 are not all zero raises the error flag for that cycle, and is neither granted nor stalled nor held.
- R8: Two loads to the same bank and the same 16-byte address are both granted in one cycle, and this does not count as a conflict for the priority rotation.
- R9: After reset no grant, stall or error is driven, and both ready outputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ld0_valid_i | input | 1 | Port 0 load request |
| ld0_addr_i | input | ADDR_W | Port 0 byte address |
| ld0_ready_o | output | 1 | Port 0 can accept a new request |
| ld0_grant_o | output | 1 | Port 0 load issued to its bank this cycle |
| ld0_stall_o | output | 1 | Port 0 load lost its bank this cycle and is held |
| ld0_bank_o | output | BANK_W | Bank targeted by port 0 |
| ld0_err_o | output | 1 | Port 0 request rejected as misaligned |
| ld1_valid_i | input | 1 | Port 1 load request |
| ld1_addr_i | input | ADDR_W | Port 1 byte address |
| ld1_ready_o | output | 1 | Port 1 can accept a new request |
| ld1_grant_o | output | 1 | Port 1 load issued to its bank this cycle |
| ld1_stall_o | output | 1 | Port 1 load lost its bank this cycle and is held |
| ld1_bank_o | output | BANK_W | Bank targeted by port 1 |
| ld1_err_o | output | 1 | Port 1 request rejected as misaligned |

## Verification
A single port sweeps all sixteen banks, which separates a correct bank field from a shifted one. Pairs in distinct banks are contrasted with pairs 256 bytes apart in the same bank, which tells parallel issue apart from a whole-array conflict rule. Back-to-back conflicts with new traffic on the stalled port distinguish held-request replay and the alternating priority from fixed priority or a request that was dropped. Misaligned addresses and identical addresses exercise the rejection and merge paths, and a later conflict shows whether a merge disturbed the rotation.

// File: rtl/lbk_pkg.sv
package lbk_pkg;
  localparam int unsigned LBK_PORTS = 2;

  typedef enum logic {
    PRI_P0 = 1'b0,
    PRI_P1 = 1'b1
  } pri_e;
endpackage

// File: rtl/lbk_rst_sync.sv
module lbk_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/lbk_port_hold.sv
module lbk_port_hold #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFF_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [ADDR_W-1:0] in_addr_i,
  input  logic              stall_i,
  output logic              ready_o,
  output logic              err_o,
  output logic              eff_valid_o,
  output logic [ADDR_W-1:0] eff_addr_o
);
  logic              held_q, held_d;
  logic [ADDR_W-1:0] haddr_q, haddr_d;
  logic              haddr_en;
  logic              accept;

  always_comb begin
    ready_o     = !held_q;
    accept      = in_valid_i && ready_o;
    err_o       = accept && (in_addr_i[OFF_W-1:0] != '0);
    eff_valid_o = held_q || (accept && !err_o);
    eff_addr_o  = held_q ? haddr_q : in_addr_i;
    held_d      = stall_i;
    haddr_en    = stall_i && !held_q;
    haddr_d     = in_addr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q  <= 1'b0;
      haddr_q <= '0;
    end else begin
      held_q <= held_d;
      if (haddr_en) haddr_q <= haddr_d;
    end
  end
endmodule

// File: rtl/lbk_resolve.sv
module lbk_resolve
  import lbk_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned OFF_W    = 4,
  parameter int unsigned BANK_W   = 4,
  parameter bit          MERGE_EN = 1'b1
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [LBK_PORTS-1:0]             req_v_i,
  input  logic [LBK_PORTS-1:0][ADDR_W-1:0] req_a_i,
  output logic [LBK_PORTS-1:0]             gnt_o,
  output logic [LBK_PORTS-1:0]             stall_o
);
  pri_e prio_q, prio_d;
  logic prio_en;
  logic same_bank, same_word, collide;

  always_comb begin
    same_bank = req_a_i[0][OFF_W +: BANK_W] == req_a_i[1][OFF_W +: BANK_W];
    same_word = req_a_i[0][ADDR_W-1:OFF_W] == req_a_i[1][ADDR_W-1:OFF_W];
    collide   = (&req_v_i) && same_bank && !(MERGE_EN && same_word);
    prio_en   = collide;
    prio_d    = (prio_q == PRI_P0) ? PRI_P1 : PRI_P0;
  end

  for (genvar p = 0; p < LBK_PORTS; p++) begin : g_port
    logic loses;
    assign loses      = collide && (prio_q != pri_e'(p));
    assign gnt_o[p]   = req_v_i[p] && !loses;
    assign stall_o[p] = req_v_i[p] && loses;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      prio_q <= PRI_P0;
    else if (prio_en) prio_q <= prio_d;
  end
endmodule

// File: rtl/lbk_arbiter.sv
module lbk_arbiter
  import lbk_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned BANKS      = 16,
  parameter int unsigned BANK_BYTES = 16,
  parameter bit          MERGE_EN   = 1'b1,
  localparam int unsigned OFF_W     = $clog2(BANK_BYTES),
  localparam int unsigned BANK_W    = $clog2(BANKS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld0_valid_i,
  input  logic [ADDR_W-1:0] ld0_addr_i,
  output logic              ld0_ready_o,
  output logic              ld0_grant_o,
  output logic              ld0_stall_o,
  output logic [BANK_W-1:0] ld0_bank_o,
  output logic              ld0_err_o,
  input  logic              ld1_valid_i,
  input  logic [ADDR_W-1:0] ld1_addr_i,
  output logic              ld1_ready_o,
  output logic              ld1_grant_o,
  output logic              ld1_stall_o,
  output logic [BANK_W-1:0] ld1_bank_o,
  output logic              ld1_err_o
);
  logic                             rst_sync_n;
  logic [LBK_PORTS-1:0]             in_v, rdy, err, eff_v, gnt, stall;
  logic [LBK_PORTS-1:0][ADDR_W-1:0] in_a, eff_a;

  lbk_rst_sync #(.STAGES(2)) u_rst (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rst_no(rst_sync_n)
  );

  assign in_v = {ld1_valid_i, ld0_valid_i};
  assign in_a = {ld1_addr_i, ld0_addr_i};

  for (genvar p = 0; p < LBK_PORTS; p++) begin : g_hold
    lbk_port_hold #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_hold (
      .clk_i      (clk_i),
      .rst_ni     (rst_sync_n),
      .in_valid_i (in_v[p]),
      .in_addr_i  (in_a[p]),
      .stall_i    (stall[p]),
      .ready_o    (rdy[p]),
      .err_o      (err[p]),
      .eff_valid_o(eff_v[p]),
      .eff_addr_o (eff_a[p])
    );
  end

  lbk_resolve #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .BANK_W(BANK_W), .MERGE_EN(MERGE_EN)
  ) u_resolve (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .req_v_i(eff_v),
    .req_a_i(eff_a),
    .gnt_o  (gnt),
    .stall_o(stall)
  );

  assign ld0_ready_o = rdy[0];
  assign ld1_ready_o = rdy[1];
  assign ld0_grant_o = gnt[0];
  assign ld1_grant_o = gnt[1];
  assign ld0_stall_o = stall[0];
  assign ld1_stall_o = stall[1];
  assign ld0_err_o   = err[0];
  assign ld1_err_o   = err[1];
  assign ld0_bank_o  = eff_a[0][OFF_W +: BANK_W];
  assign ld1_bank_o  = eff_a[1][OFF_W +: BANK_W];
endmodule

// File: rtl/lbk_arbiter_chk.sv
module lbk_arbiter_chk #(
  parameter int unsigned BANK_W = 4
) (
  input logic              clk_i,
  input logic              rst_n,
  input logic              ld0_ready_o,
  input logic              ld0_grant_o,
  input logic              ld0_stall_o,
  input logic [BANK_W-1:0] ld0_bank_o,
  input logic              ld0_err_o,
  input logic              ld1_ready_o,
  input logic              ld1_grant_o,
  input logic              ld1_stall_o,
  input logic [BANK_W-1:0] ld1_bank_o,
  input logic              ld1_err_o
);
  AST_DIFF_BANK_BOTH: assert property (@(posedge clk_i) disable iff (!rst_n)
    ((ld0_grant_o || ld0_stall_o) && (ld1_grant_o || ld1_stall_o) && (ld0_bank_o != ld1_bank_o))
      |-> (ld0_grant_o && ld1_grant_o)); // R2
  AST_ONE_LOSER: assert property (@(posedge clk_i) disable iff (!rst_n)
    !(ld0_stall_o && ld1_stall_o)); // R3
  AST_P0_WINS_AFTER_LOSS: assert property (@(posedge clk_i) disable iff (!rst_n)
    ld0_stall_o |=> ld0_grant_o); // R4
  AST_P1_WINS_AFTER_LOSS: assert property (@(posedge clk_i) disable iff (!rst_n)
    ld1_stall_o |=> ld1_grant_o); // R4
  AST_HELD_BANK_KEPT: assert property (@(posedge clk_i) disable iff (!rst_n)
    ld0_stall_o |=> (ld0_bank_o == $past(ld0_bank_o))); // R5
  AST_HELD_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_n)
    ld1_stall_o |=> !ld1_ready_o); // R5
  AST_NOT_READY_NO_ERR: assert property (@(posedge clk_i) disable iff (!rst_n)
    !ld0_ready_o |-> !ld0_err_o); // R6
  AST_ERR_NO_ISSUE: assert property (@(posedge clk_i) disable iff (!rst_n)
    (ld0_err_o |-> !(ld0_grant_o || ld0_stall_o)) and (ld1_err_o |-> !(ld1_grant_o || ld1_stall_o))); // R7
  AST_ERR_NOT_HELD: assert property (@(posedge clk_i) disable iff (!rst_n)
    ld1_err_o |=> ld1_ready_o); // R7
endmodule

bind lbk_arbiter lbk_arbiter_chk #(.BANK_W(BANK_W)) u_chk (
  .clk_i      (clk_i),
  .rst_n      (rst_sync_n),
  .ld0_ready_o(ld0_ready_o),
  .ld0_grant_o(ld0_grant_o),
  .ld0_stall_o(ld0_stall_o),
  .ld0_bank_o (ld0_bank_o),
  .ld0_err_o  (ld0_err_o),
  .ld1_ready_o(ld1_ready_o),
  .ld1_grant_o(ld1_grant_o),
  .ld1_stall_o(ld1_stall_o),
  .ld1_bank_o (ld1_bank_o),
  .ld1_err_o  (ld1_err_o)
);

// File: tb/tb_lbk_arbiter.sv
module tb_lbk_arbiter;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        ld0_valid_i, ld1_valid_i;
  logic [31:0] ld0_addr_i, ld1_addr_i;
  logic        ld0_ready_o, ld0_grant_o, ld0_stall_o, ld0_err_o;
  logic        ld1_ready_o, ld1_grant_o, ld1_stall_o, ld1_err_o;
  logic [3:0]  ld0_bank_o, ld1_bank_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // behavioural model state
  bit          m_held [2];
  logic [31:0] m_haddr [2];
  int          m_prio;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  lbk_arbiter dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .ld0_valid_i(ld0_valid_i), .ld0_addr_i(ld0_addr_i), .ld0_ready_o(ld0_ready_o),
    .ld0_grant_o(ld0_grant_o), .ld0_stall_o(ld0_stall_o), .ld0_bank_o(ld0_bank_o),
    .ld0_err_o(ld0_err_o),
    .ld1_valid_i(ld1_valid_i), .ld1_addr_i(ld1_addr_i), .ld1_ready_o(ld1_ready_o),
    .ld1_grant_o(ld1_grant_o), .ld1_stall_o(ld1_stall_o), .ld1_bank_o(ld1_bank_o),
    .ld1_err_o(ld1_err_o)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit v0, input logic [31:0] a0,
                      input bit v1, input logic [31:0] a1, input string tag);
    bit iv [2];
    logic [31:0] ia [2];
    logic [31:0] ea [2];
    bit rdy [2], err [2], ev [2], g [2], s [2];
    bit col;
    int abank [2];
    int aflag [2][4];
    @(negedge clk_i);
    ld0_valid_i = v0; ld0_addr_i = a0;
    ld1_valid_i = v1; ld1_addr_i = a1;
    #1;
    iv[0] = v0; iv[1] = v1; ia[0] = a0; ia[1] = a1;
    for (int p = 0; p < 2; p++) begin
      rdy[p] = !m_held[p];
      err[p] = iv[p] && rdy[p] && (ia[p][3:0] != 4'h0);
      ev[p]  = m_held[p] || (iv[p] && rdy[p] && !err[p]);
      ea[p]  = m_held[p] ? m_haddr[p] : ia[p];
    end
    col = ev[0] && ev[1] && (ea[0][7:4] == ea[1][7:4]) && (ea[0][31:4] != ea[1][31:4]);
    for (int p = 0; p < 2; p++) begin
      g[p] = ev[p] && !(col && p != m_prio);
      s[p] = ev[p] && !g[p];
    end
    aflag[0] = '{int'(ld0_ready_o), int'(ld0_grant_o), int'(ld0_stall_o), int'(ld0_err_o)};
    aflag[1] = '{int'(ld1_ready_o), int'(ld1_grant_o), int'(ld1_stall_o), int'(ld1_err_o)};
    abank[0] = int'(ld0_bank_o);
    abank[1] = int'(ld1_bank_o);
    for (int p = 0; p < 2; p++) begin
      chk(tag, $sformatf("port%0d ready", p), aflag[p][0], int'(rdy[p]));
      chk(tag, $sformatf("port%0d grant", p), aflag[p][1], int'(g[p]));
      chk(tag, $sformatf("port%0d stall", p), aflag[p][2], int'(s[p]));
      chk(tag, $sformatf("port%0d err", p), aflag[p][3], int'(err[p]));
      if (g[p] || s[p]) chk("R1", $sformatf("port%0d bank", p), abank[p], int'(ea[p][7:4]));
    end
    for (int p = 0; p < 2; p++) begin
      if (s[p] && !m_held[p]) m_haddr[p] = ia[p];
      m_held[p] = s[p];
    end
    if (col) m_prio = 1 - m_prio;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    m_held = '{0, 0};
    m_haddr = '{32'h0, 32'h0};
    m_prio = 0;
    rst_ni = 1'b0;
    ld0_valid_i = 1'b0; ld0_addr_i = '0;
    ld1_valid_i = 1'b0; ld1_addr_i = '0;
    repeat (4) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    // R9: idle state after reset
    chk("R9", "ready0", int'(ld0_ready_o), 1);
    chk("R9", "ready1", int'(ld1_ready_o), 1);
    chk("R9", "grants", int'({ld0_grant_o, ld1_grant_o}), 0);
    chk("R9", "stalls", int'({ld0_stall_o, ld1_stall_o}), 0);
    chk("R9", "errs",   int'({ld0_err_o, ld1_err_o}), 0);

    // R1: every bank on port 0, then on port 1
    for (int b = 0; b < 16; b++) step(1, 32'h300 + b * 16, 0, 32'h0, "R1");
    for (int b = 0; b < 16; b++) step(0, 32'h0, 1, 32'h1200 + b * 16, "R1");

    // R2: different banks in parallel
    step(1, 32'h1000, 1, 32'h1010, "R2");
    step(1, 32'h2050, 1, 32'h30A0, "R2");
    step(1, 32'h40F0, 1, 32'h4000, "R2");

    // R3: 256-byte stride conflict, port 0 wins first (R4), replay next (R5)
    step(1, 32'h4000, 1, 32'h4100, "R3");
    step(0, 32'h0, 0, 32'h0, "R5");

    // R4: alternating priority; R6: new input ignored while held
    step(1, 32'h5000, 1, 32'h5200, "R4");
    step(1, 32'h6000, 1, 32'h7000, "R4");
    step(0, 32'h0, 0, 32'h0, "R5");

    step(1, 32'h8000, 1, 32'h8100, "R6");
    step(1, 32'h8010, 0, 32'h0, "R6");
    step(0, 32'h0, 0, 32'h0, "R6");

    // R7: misaligned requests rejected, not held
    step(1, 32'h9004, 1, 32'h9100, "R7");
    step(0, 32'h0, 1, 32'h920F, "R7");
    step(0, 32'h0, 0, 32'h0, "R7");

    // R8: same 16-byte word merged, rotation unchanged
    step(1, 32'hA040, 1, 32'hA040, "R8");
    step(1, 32'hA040, 1, 32'hA140, "R8");
    step(0, 32'h0, 0, 32'h0, "R8");

    // R3: long same-bank stride stream on both ports
    for (int k = 0; k < 12; k++)
      step(1, 32'h10000 + k * 512, 1, 32'h10100 + k * 512, "R3");
    step(0, 32'h0, 0, 32'h0, "R5");
    step(0, 32'h0, 0, 32'h0, "R5");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule